// File: doc/BRIEF.md
# Bidirectional Port With Pulldown Control

This block is an 8-bit general-purpose I/O port. Software reaches it through a byte-wide register bus. It holds three registers. The output latch supplies the level driven on each pin. The direction register decides, pin by pin, whether the driver is on. The pulldown-inhibit register is write-only and switches each pin's weak pulldown off. A pulldown is only ever active on a pin that is an input. Reading the data address returns the latch for output pins and the synchronized pad level for input pins.

The low four pins also act as wake/interrupt sources. All pin levels pass through a two-flop synchronizer. A rising edge on any of pins 3..0 moves a small controller from `IRQ_IDLE` to `IRQ_PENDING`, and this happens whatever the direction of the pin. The controller returns from `IRQ_PENDING` to `IRQ_IDLE` on an acknowledge strobe, unless a new edge arrives in that same cycle, in which case it stays in `IRQ_PENDING`. In the edge-plus-level mode, the request output is also held high while any of pins 3..0 is high.

Top module: `bidir_port_ctl`

## Requirements
- R1: After reset the direction register is 0x00 (every `pin_oe` bit low), every `pin_pd_en` bit is high, the pulldown-inhibit register is 0x00 and `irq_req` is low. The output latch keeps its value across reset.
- R2: A write to address 0x04 loads the direction register. `pin_oe` equals that register from the next cycle, with bit value 1 meaning output. A read of 0x04 returns it.
- R3: A write to address 0x00 loads the output latch whatever the direction. `pin_out` equals the latch from the next cycle.
- R4: A read of address 0x00 returns, for each bit, the latch bit where the direction bit is 1 and the synchronized pin bit where it is 0.
- R5: A write to address 0x10 loads the pulldown-inhibit register. `pin_pd_en[i]` is high exactly when inhibit bit i is 0 and direction bit i is 0.
- R6: A read of address 0x10 returns 0x00.
- R7: A rising edge on any of `pin_in[3:0]` sets the interrupt latch, whatever the pin's direction. Edges on `pin_in[7:4]` have no effect on it.
- R8: With `irq_mode`=1, `irq_req` is also high while any synchronized `pin_in[3:0]` bit is high. With `irq_mode`=0, only the latch drives `irq_req`.
- R9: `irq_ack`=1 clears the latch in the next cycle. If a rising edge is detected in the same cycle as the acknowledge, the latch stays set.
- R10: A change on `pin_in` is visible on the read path two clock edges later: it is not visible after one edge and is visible after two.
- R11: Reads of any other address return 0x00, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Output latch driven to pads |
| pin_oe | output | 8 | Per-pin driver enable |
| pin_pd_en | output | 8 | Per-pin pulldown enable |
| irq_mode | input | 1 | 0 = edge only, 1 = edge plus high level |
| irq_ack | input | 1 | Clear strobe for the interrupt latch |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench sends an edge on pin 1 in the very cycle that `irq_ack` is pulsed. A design that let the clear win would drop the request and lose that edge. It raises pin 0 while pin 0 is configured as an output, and it toggles pins 7..4, so a design that gated edges by direction, or that watched all eight pins, would report the wrong request level. Mixed-direction readback and the pulldown override are checked with patterns where latch, pad and inhibit values all differ, so swapped selects show up. Readback is sampled one and two edges after a pad change, which exposes a synchronizer with the wrong depth.

// File: rtl/port_pkg.sv
package port_pkg;
    localparam int PORT_W = 8;
    localparam int IRQ_W  = 4;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_DIR  = 5'h04;
    localparam logic [ADDR_W-1:0] ADDR_PDI  = 5'h10;

    typedef enum logic [0:0] {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_t;
endpackage

// File: rtl/port_sync.sv
module port_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/port_regs.sv
module port_regs
    import port_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  pin_sync,
    output logic [W-1:0]  bus_rdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  pd_en
);
    logic [W-1:0] pdi_q;
    logic wr_data, wr_dir, wr_pdi;

    assign wr_data = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
    assign wr_dir  = bus_sel && bus_wr && (bus_addr == ADDR_DIR);
    assign wr_pdi  = bus_sel && bus_wr && (bus_addr == ADDR_PDI);

    // Output latch: deliberately not reset
    always_ff @(posedge clk) begin
        if (wr_data) latch_q <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            pdi_q <= '0;
        end else begin
            if (wr_dir) dir_q <= bus_wdata;
            if (wr_pdi) pdi_q <= bus_wdata;
        end
    end

    // Pulldown only on inputs whose inhibit bit is clear
    assign pd_en = ~pdi_q & ~dir_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                ADDR_DATA: bus_rdata = (dir_q & latch_q) | (~dir_q & pin_sync);
                ADDR_DIR:  bus_rdata = dir_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> dir_q == $past(bus_wdata));

    assert_dir_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));

    assert_pdi_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pdi |=> $stable(pdi_q));
endmodule

// File: rtl/port_irq.sv
module port_irq
    import port_pkg::*;
#(
    parameter int W = IRQ_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         level_mode,
    input  logic         ack,
    output logic         req
);
    irq_state_t   state_q, state_d;
    logic [W-1:0] prev_q;
    logic         rise_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pins;
    end

    assign rise_any = |(pins & ~prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (rise_any) state_d = IRQ_PENDING;
            IRQ_PENDING: if (ack && !rise_any) state_d = IRQ_IDLE;
            default:     state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        req = (state_q == IRQ_PENDING) || (level_mode && (|pins));
    end

    assert_edge_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_any |=> state_q == IRQ_PENDING);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !rise_any) |=> state_q == IRQ_IDLE);

    assert_idle_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_IDLE && !level_mode) |-> !req);
endmodule

// File: rtl/bidir_port_ctl.sv
module bidir_port_ctl
    import port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_pd_en,
    input  logic              irq_mode,
    input  logic              irq_ack,
    output logic              irq_req
);
    logic [PORT_W-1:0] pin_sync;

    port_sync #(.W(PORT_W), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    port_regs #(.W(PORT_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .dir_q     (pin_oe),
        .latch_q   (pin_out),
        .pd_en     (pin_pd_en)
    );

    port_irq #(.W(IRQ_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins       (pin_sync[IRQ_W-1:0]),
        .level_mode (irq_mode),
        .ack        (irq_ack),
        .req        (irq_req)
    );

    assert_oe_no_pd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe[0]) |-> !pin_pd_en[0]);
endmodule

// File: tb/sim_bidir_port_ctl.sv
module sim_bidir_port_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe, pin_pd_en;
    logic       irq_mode = 1'b0, irq_ack = 1'b0;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bidir_port_ctl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pd_en(pin_pd_en), .irq_mode(irq_mode), .irq_ack(irq_ack),
        .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk);
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 pd_en", pin_pd_en, 8'hFF);
        chk("R1 irq", {7'd0, irq_req}, 8'h00);
        rd(5'h04, v); chk("R1 dir read", v, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] v;
        wr(5'h04, 8'hA5);
        chk("R2 oe", pin_oe, 8'hA5);
        rd(5'h04, v); chk("R2 dir read", v, 8'hA5);
        chk("R5 pd follows dir", pin_pd_en, 8'h5A);
    endtask

    task automatic t_latch();
        wr(5'h04, 8'h00);
        wr(5'h00, 8'h3C);
        chk("R3 latch as input", pin_out, 8'h3C);
        wr(5'h04, 8'hFF);
        chk("R3 latch kept", pin_out, 8'h3C);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        wr(5'h04, 8'hF0);
        wr(5'h00, 8'hAA);
        pin_in = 8'h55;
        cyc(3);
        rd(5'h00, v); chk("R4 mixed read", v, 8'hA5);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        wr(5'h04, 8'h00);
        pin_in = 8'h00;
        cyc(3);
        pin_in = 8'h81;
        @(negedge clk);
        rd(5'h00, v); chk("R10 one edge", v, 8'h00);
        @(negedge clk);
        rd(5'h00, v); chk("R10 two edges", v, 8'h81);
        pin_in = 8'h00;
        cyc(3);
    endtask

    task automatic t_pulldown();
        logic [7:0] v;
        wr(5'h04, 8'h0F);
        wr(5'h10, 8'h33);
        chk("R5 pd_en", pin_pd_en, 8'hC0);
        rd(5'h10, v); chk("R6 pdi read", v, 8'h00);
        wr(5'h10, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(5'h04, 8'h3C);
        wr(5'h00, 8'h99);
        wr(5'h08, 8'hFF);
        wr(5'h1F, 8'h00);
        chk("R11 oe unchanged", pin_oe, 8'h3C);
        chk("R11 pd unchanged", pin_pd_en, 8'hC3);
        chk("R11 latch unchanged", pin_out, 8'h99);
        rd(5'h08, v); chk("R11 read zero", v, 8'h00);
    endtask

    task automatic t_edge();
        irq_mode = 1'b0;
        pin_in = 8'h00;
        wr(5'h04, 8'h01);
        cyc(3);
        ack_pulse();
        pin_in = 8'h01;
        cyc(4);
        chk("R7 edge on output pin", {7'd0, irq_req}, 8'h01);
        ack_pulse();
        chk("R9 ack clears", {7'd0, irq_req}, 8'h00);
        cyc(2);
        chk("R8 edge mode ignores level", {7'd0, irq_req}, 8'h00);
        pin_in = 8'hF1;
        cyc(4);
        chk("R7 upper pins ignored", {7'd0, irq_req}, 8'h00);
        pin_in = 8'h00;
        cyc(3);
    endtask

    task automatic t_level();
        irq_mode = 1'b1;
        pin_in = 8'h04;
        cyc(4);
        chk("R8 level high", {7'd0, irq_req}, 8'h01);
        ack_pulse();
        chk("R8 level holds after ack", {7'd0, irq_req}, 8'h01);
        pin_in = 8'h00;
        cyc(3);
        chk("R8 level released", {7'd0, irq_req}, 8'h00);
        irq_mode = 1'b0;
    endtask

    task automatic t_ack_race();
        pin_in = 8'h02;
        cyc(4);
        chk("R9 pending before race", {7'd0, irq_req}, 8'h01);
        pin_in = 8'h00;
        cyc(3);
        pin_in = 8'h02;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk("R9 edge beats ack", {7'd0, irq_req}, 8'h01);
        ack_pulse();
        chk("R9 later ack clears", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_latch_reset();
        wr(5'h00, 8'h6E);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 latch kept over reset", pin_out, 8'h6E);
        chk("R1 oe after reset", pin_oe, 8'h00);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_direction();
        t_latch();
        t_readback();
        t_sync();
        t_pulldown();
        t_unmapped();
        t_edge();
        t_level();
        t_ack_race();
        t_latch_reset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule